// File: doc/BRIEF.md
# 24x24 Dadda Tree Significand Multiplier

This block multiplies two unsigned 24-bit significands and presents the full 48-bit product. It has no clock and holds no state: the operands flow through an AND array, a Dadda column-compression tree and a carry-lookahead adder, and the product is valid as soon as that logic settles.

Each bit of operand A is ANDed with each bit of operand B, which gives 576 partial-product dots. Dot (i, k) sits in column i+k. The tree then compresses the columns in seven stages with the row-height limits 19, 13, 9, 6, 4, 3 and 2. In each stage, each column is compressed with full and half adders just enough to meet the limit. Each carry moves to the next more significant column. Column 0 only ever holds one dot, and it becomes product bit 0. Columns 1 to 47 are left with two rows. A 47-bit adder built from 4-bit lookahead groups adds those two rows and supplies product bits 1 to 47.

A floating-point multiplier would place this block on its significand path. That unit normalizes from the top two product bits, and it takes its rounding bits from the bits just below them.

Top module: `dadda_mult24`

## Requirements
- R1: For all operand pairs, `prod_o` equals the unsigned product of `opa_i` and `opb_i` as a 48-bit value. The carry out of the final adder is always 0.
- R2: When either operand is zero, the product is zero.
- R3: When one operand equals 1, the product equals the other operand, zero-extended to 48 bits.
- R4: Product bit 0 equals `opa_i[0] & opb_i[0]`. The second reduced row holds no bit in column 0.
- R5: When bit 23 of both operands is set, `prod_o[47:46]` is nonzero.
- R6: When bit 23 is clear in both operands, `prod_o[47:46]` is 00.
- R7: All-ones operands (0xFFFFFF times 0xFFFFFF) give 0xFFFFFE000001.
- R8: When each operand has exactly one bit set, at positions i and j, the product has exactly one bit set, at position i+j.
- R9: The block is purely combinational. A new operand pair gives its product within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 24 | Unsigned multiplicand (significand A) |
| opb_i | input | 24 | Unsigned multiplier (significand B) |
| prod_o | output | 48 | Unsigned product A*B |

## Verification
Every result is due in the clock period in which its operands are applied, because no register lies between the ports. The bench changes the operands on the falling edge and samples the product 1 ns later, well before the next rising edge. One directed check also changes the operands and samples again within a single period, with no edge in between. This catches any storage element that might have slipped into the path.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

  // Dadda height limit for stage index j: d0 = 2, d(j+1) = floor(1.5 * d(j))
  function automatic int dadda_d(input int j);
    int d;
    d = 2;
    for (int i = 0; i < j; i++) d = (d * 3) / 2;
    return d;
  endfunction

  // Index of the largest Dadda limit strictly below height h
  function automatic int dadda_first(input int h);
    int j;
    j = 0;
    for (int i = 0; i < 32; i++)
      if (dadda_d(i + 1) < h) j = i + 1;
    return j;
  endfunction

  function automatic int min_int(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

endpackage

// File: rtl/dadda_ppgen.sv
module dadda_ppgen #(
  parameter int A_W = 24,
  parameter int B_W = 24
) (
  input  logic [A_W-1:0]            opa_i,
  input  logic [B_W-1:0]            opb_i,
  output logic [A_W-1:0][B_W-1:0]   dot_o
);
  // dot (i,k) carries weight 2^(i+k)
  for (genvar i = 0; i < A_W; i++) begin : g_row
    for (genvar k = 0; k < B_W; k++) begin : g_col
      assign dot_o[i][k] = opa_i[i] & opb_i[k];
    end
  end
endmodule

// File: rtl/dadda_reduce.sv
module dadda_reduce
  import dadda_pkg::*;
#(
  parameter int A_W = 24,
  parameter int B_W = 24,
  localparam int COLS = A_W + B_W
) (
  input  logic [A_W-1:0][B_W-1:0] dot_i,
  output logic [COLS-1:0]         row0_o,
  output logic [COLS-1:0]         row1_o
);
  localparam int ROWS   = min_int(A_W, B_W);
  localparam int CIW    = $clog2(COLS);
  localparam int RIW    = $clog2(ROWS);
  localparam int TOP_ST = dadda_first(ROWS);

  function automatic logic [2*COLS-1:0] compress(input logic [A_W-1:0][B_W-1:0] dots);
    logic [ROWS-1:0] cur [COLS];
    logic [ROWS-1:0] nxt [COLS];
    int cnt  [COLS];
    int ncnt [COLS];
    int d, ex, nf, nh, tk;
    logic x, y, z;
    logic [COLS-1:0] r0, r1;

    for (int c = 0; c < COLS; c++) begin
      cur[CIW'(c)] = '0;
      cnt[CIW'(c)] = 0;
    end
    // load the dot matrix, column by column
    for (int i = 0; i < A_W; i++) begin
      for (int k = 0; k < B_W; k++) begin
        cur[CIW'(i + k)][RIW'(cnt[CIW'(i + k)])] = dots[i][k];
        cnt[CIW'(i + k)] = cnt[CIW'(i + k)] + 1;
      end
    end

    for (int s = TOP_ST; s >= 0; s--) begin
      d = dadda_d(s);
      for (int c = 0; c < COLS; c++) begin
        nxt[CIW'(c)]  = '0;
        ncnt[CIW'(c)] = 0;
      end
      for (int c = 0; c < COLS; c++) begin
        // carries already parked in ncnt[c] count towards this column's height
        ex = cnt[CIW'(c)] + ncnt[CIW'(c)] - d;
        nf = (ex > 0) ? ex / 2 : 0;
        nh = (ex > 0) ? ex % 2 : 0;
        tk = 0;
        for (int f = 0; f < ROWS; f++) begin
          if (f < nf) begin
            x = cur[CIW'(c)][RIW'(tk)];
            y = cur[CIW'(c)][RIW'(tk + 1)];
            z = cur[CIW'(c)][RIW'(tk + 2)];
            nxt[CIW'(c)][RIW'(ncnt[CIW'(c)])] = x ^ y ^ z;
            ncnt[CIW'(c)] = ncnt[CIW'(c)] + 1;
            if (c + 1 < COLS) begin
              nxt[CIW'(c + 1)][RIW'(ncnt[CIW'(c + 1)])] = (x & y) | (x & z) | (y & z);
              ncnt[CIW'(c + 1)] = ncnt[CIW'(c + 1)] + 1;
            end
            tk = tk + 3;
          end
        end
        if (nh == 1) begin
          x = cur[CIW'(c)][RIW'(tk)];
          y = cur[CIW'(c)][RIW'(tk + 1)];
          nxt[CIW'(c)][RIW'(ncnt[CIW'(c)])] = x ^ y;
          ncnt[CIW'(c)] = ncnt[CIW'(c)] + 1;
          if (c + 1 < COLS) begin
            nxt[CIW'(c + 1)][RIW'(ncnt[CIW'(c + 1)])] = x & y;
            ncnt[CIW'(c + 1)] = ncnt[CIW'(c + 1)] + 1;
          end
          tk = tk + 2;
        end
        // untouched dots pass straight into the next stage
        for (int k = 0; k < ROWS; k++) begin
          if (k >= tk && k < cnt[CIW'(c)]) begin
            nxt[CIW'(c)][RIW'(ncnt[CIW'(c)])] = cur[CIW'(c)][RIW'(k)];
            ncnt[CIW'(c)] = ncnt[CIW'(c)] + 1;
          end
        end
      end
      cur = nxt;
      cnt = ncnt;
    end

    for (int c = 0; c < COLS; c++) begin
      r0[CIW'(c)] = cur[CIW'(c)][0];
      r1[CIW'(c)] = cur[CIW'(c)][1];
    end
    return {r1, r0};
  endfunction

  assign {row1_o, row0_o} = compress(dot_i);
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] x_i,
  input  logic [GW-1:0] y_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          cout_o
);
  logic [GW-1:0] gen, prp;
  logic [GW:0]   cy;
  logic          term;

  assign gen = x_i & y_i;
  assign prp = x_i ^ y_i;

  // each carry expanded from generate/propagate terms and the group carry-in
  always_comb begin
    cy[0] = cin_i;
    for (int i = 0; i < GW; i++) begin
      term = cin_i;
      for (int j = 0; j <= i; j++) term = term & prp[j];
      cy[i + 1] = term;
      for (int j = 0; j <= i; j++) begin
        term = gen[j];
        for (int m = j + 1; m <= i; m++) term = term & prp[m];
        cy[i + 1] = cy[i + 1] | term;
      end
    end
  end

  assign sum_o  = prp ^ cy[GW-1:0];
  assign cout_o = cy[GW];
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int W  = 47,
  parameter int GW = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  localparam int NG = (W + GW - 1) / GW;
  localparam int WP = NG * GW;

  logic [WP-1:0] xp, yp, sp;
  logic [NG:0]   gc;
  logic [WP:0]   full;

  assign xp    = {{(WP-W){1'b0}}, x_i};
  assign yp    = {{(WP-W){1'b0}}, y_i};
  assign gc[0] = 1'b0;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    cla_group #(.GW(GW)) u_grp (
      .x_i   (xp[g*GW +: GW]),
      .y_i   (yp[g*GW +: GW]),
      .cin_i (gc[g]),
      .sum_o (sp[g*GW +: GW]),
      .cout_o(gc[g+1])
    );
  end

  assign full  = {gc[NG], sp};
  assign sum_o = full[W-1:0];
  assign co_o  = |full[WP:W];
endmodule

// File: rtl/dadda_mult24.sv
module dadda_mult24 #(
  parameter int A_W = 24,
  parameter int B_W = 24
) (
  input  logic [A_W-1:0]     opa_i,
  input  logic [B_W-1:0]     opb_i,
  output logic [A_W+B_W-1:0] prod_o
);
  localparam int PW = A_W + B_W;

  logic [A_W-1:0][B_W-1:0] dots;
  logic [PW-1:0]           row0, row1;
  logic [PW-2:0]           upper;
  logic                    fin_co;

  dadda_ppgen #(.A_W(A_W), .B_W(B_W)) u_pp (
    .opa_i(opa_i),
    .opb_i(opb_i),
    .dot_o(dots)
  );

  dadda_reduce #(.A_W(A_W), .B_W(B_W)) u_tree (
    .dot_i (dots),
    .row0_o(row0),
    .row1_o(row1)
  );

  cla_adder #(.W(PW-1), .GW(4)) u_cpa (
    .x_i  (row0[PW-1:1]),
    .y_i  (row1[PW-1:1]),
    .sum_o(upper),
    .co_o (fin_co)
  );

  assign prod_o = {upper, row0[0]};
endmodule

// File: rtl/dadda_mult24_chk.sv
module dadda_mult24_chk #(
  parameter int A_W = 24,
  parameter int B_W = 24
) (
  input logic [A_W-1:0]     opa_i,
  input logic [B_W-1:0]     opb_i,
  input logic [A_W+B_W-1:0] prod_o,
  input logic               row1_lsb,
  input logic               fin_co
);
  localparam int PW = A_W + B_W;

  always_comb begin
    // R1
    no_final_carry_chk: assert (!fin_co) else $error("final adder carried out");
    // R2
    if (opa_i == '0 || opb_i == '0)
      zero_operand_chk: assert (prod_o == '0) else $error("zero operand, nonzero product");
    // R3
    if (opa_i == A_W'(1))
      unit_operand_chk: assert (prod_o == PW'(opb_i)) else $error("unit operand mismatch");
    // R4
    lsb_dot_chk: assert (prod_o[0] == (opa_i[0] & opb_i[0]) && !row1_lsb) else $error("bit 0 wrong");
    // R5
    if (opa_i[A_W-1] && opb_i[B_W-1])
      msb_pair_set_chk: assert (prod_o[PW-1:PW-2] != 2'b00) else $error("top pair empty");
    // R6
    if (!opa_i[A_W-1] && !opb_i[B_W-1])
      msb_pair_clear_chk: assert (prod_o[PW-1:PW-2] == 2'b00) else $error("top pair set");
  end
endmodule

bind dadda_mult24 dadda_mult24_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .prod_o  (prod_o),
  .row1_lsb(row1[0]),
  .fin_co  (fin_co)
);

// File: tb/tb_dadda_mult24.sv
`timescale 1ns/1ps
module tb_dadda_mult24;
  logic        clk;
  logic        rst_n;
  logic [23:0] opa, opb;
  logic [47:0] prod;
  int          n_vec, n_bad;
  bit          done;

  dadda_mult24 dut (.opa_i(opa), .opb_i(opb), .prod_o(prod));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [47:0] OPS [12] = '{
    {24'h000000, 24'h123456}, {24'hABCDEF, 24'h000000},
    {24'h000001, 24'hFEDCBA}, {24'h7A5A5A, 24'h000001},
    {24'hFFFFFF, 24'hFFFFFF}, {24'h800000, 24'h800000},
    {24'hC00000, 24'hFFFFFF}, {24'h7FFFFF, 24'h7FFFFF},
    {24'hAAAAAA, 24'h555555}, {24'h123456, 24'h654321},
    {24'h800001, 24'hFFFFFE}, {24'h0F0F0F, 24'hF0F0F0}
  };

  function automatic logic [47:0] ref_mul(input logic [23:0] a, input logic [23:0] b);
    return {24'b0, a} * {24'b0, b};
  endfunction

  task automatic apply_chk(input logic [23:0] a, input logic [23:0] b,
                           input logic [47:0] exp, input string tag);
    @(negedge clk);
    opa = a;
    opb = b;
    #1;
    n_vec++;
    if (prod !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h actual=%h expected=%h", tag, a, b, prod, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    opa   = '0;
    opb   = '0;
    repeat (3) @(posedge clk);
    // R2 quiescent state: zero operands during reset
    #1;
    n_vec++;
    if (prod !== 48'h0) begin
      n_bad++;
      $display("FAIL R2 reset state: actual=%h expected=%h", prod, 48'h0);
    end
    rst_n = 1'b1;

    // R1 table walk, reference multiply
    foreach (OPS[i]) apply_chk(OPS[i][47:24], OPS[i][23:0],
                               ref_mul(OPS[i][47:24], OPS[i][23:0]), "R1 table");

    // R2 zero operands
    apply_chk(24'h000000, 24'hFFFFFF, 48'h0, "R2 zero a");
    apply_chk(24'hFFFFFF, 24'h000000, 48'h0, "R2 zero b");
    // R3 unit operand
    apply_chk(24'h000001, 24'hC3A5F0, 48'h0000_00C3A5F0, "R3 unit a");
    apply_chk(24'h9E3779, 24'h000001, 48'h0000_009E3779, "R3 unit b");
    // R4 bit 0
    apply_chk(24'h000003, 24'h000005, 48'h00000000000F, "R4 odd*odd");
    apply_chk(24'h000002, 24'h000007, 48'h00000000000E, "R4 even*odd");
    // R5 both normalized: top pair nonzero
    apply_chk(24'h800000, 24'h800000, 48'h400000000000, "R5 min normals");
    apply_chk(24'hFFFFFF, 24'h800000, 48'h7FFFFF800000, "R5 mixed normals");
    // R6 both below 2^23: top pair clear
    apply_chk(24'h7FFFFF, 24'h7FFFFF, 48'h3FFFFF000001, "R6 max subnormals");
    // R7 all ones
    apply_chk(24'hFFFFFF, 24'hFFFFFF, 48'hFFFFFE000001, "R7 all ones");

    // R8 single set bits
    for (int i = 0; i < 24; i += 3)
      for (int j = 0; j < 24; j += 5)
        apply_chk(24'h1 << i, 24'h1 << j, 48'h1 << (i + j), "R8 single bits");

    // R9 two operand pairs inside one clock period, no edge between samples
    @(negedge clk);
    opa = 24'h00ABCD;
    opb = 24'h001234;
    #0.5;
    n_vec++;
    if (prod !== ref_mul(24'h00ABCD, 24'h001234)) begin
      n_bad++;
      $display("FAIL R9 first pair: actual=%h expected=%h", prod, ref_mul(24'h00ABCD, 24'h001234));
    end
    opa = 24'hF00F00;
    opb = 24'h0FF0FF;
    #0.5;
    n_vec++;
    if (prod !== ref_mul(24'hF00F00, 24'h0FF0FF)) begin
      n_bad++;
      $display("FAIL R9 second pair: actual=%h expected=%h", prod, ref_mul(24'hF00F00, 24'h0FF0FF));
    end

    // R1 pseudo-random operands
    seed = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      logic [23:0] ra, rb;
      seed = seed * 32'd1664525 + 32'd1013904223;
      ra   = seed[31:8];
      seed = seed * 32'd1664525 + 32'd1013904223;
      rb   = seed[31:8];
      apply_chk(ra, rb, ref_mul(ra, rb), "R1 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule